// File: doc/BRIEF.md
# Flash Bulk Erase Sequencer

This block runs the whole-array erase procedure of a byte-wide flash memory. It issues commands and reads over a simple request/acknowledge bus cycle port, and it waits a set number of clock cycles between steps. A separate programming engine does the byte programming. This block hands it one address at a time, always with zero data, so that every cell starts from the same charge state before high voltage is applied.

After the pre-program pass, the sequencer applies an erase pulse. A pulse is two back-to-back writes of the erase code, followed by a long settle interval. It then sweeps the array with verify operations. A verify writes the verify code at the target address, waits a short interval, then reads that byte. The byte is good when it reads as all ones. When a byte comes back with zeros in it, the sweep stops and another pulse is applied. The sweep then restarts at that same byte, not at address zero. The run ends in one of two ways. If the sweep reaches the last address, a read-array command is written and the block reports success. If a byte still fails after the maximum number of pulses, the block reports failure.

A host starts a run with a one-cycle start strobe. It must also provide a flag that says the high-voltage supply has settled. The block requests that supply for the whole of a run.

Top module: `erase_seq`

## Requirements
- R1: Out of reset, busy, passFlag, failFlag, hvEnable, busReq and pgmReq are all 0.
- R2: A start strobe while idle raises busy and hvEnable. No pgmReq or busReq is issued while hvReady is 0.
- R3: Before the first bus cycle, pgmReq is issued once for each address from 0 up to LAST_ADDR, in ascending order, with pgmData = 00h.
- R4: If the programming engine answers pgmDone with pgmOk = 0, the run stops at once with failFlag = 1, and no bus cycle is issued.
- R5: An erase pulse is two consecutive bus writes of 20h. At least ERASE_WAIT_CYC idle cycles pass between the acknowledge of the second write and the next bus request.
- R6: A verify is a bus write of A0h at the target address, followed by at least VERIFY_WAIT_CYC idle cycles, followed by a bus read (busWrite = 0) at the same address. A byte counts as erased only when busRdata = FFh. A bus request holds its address and data until busAck.
- R7: The first verify sweep starts at address 0 and moves up by one after each erased byte. After a failing byte, the next verify after the new pulse targets that same failing address.
- R8: When a verify fails after PULSE_LIMIT pulses, the run ends with failFlag = 1 and no further pulse. At most PULSE_LIMIT pulses are applied in a run.
- R9: When the byte at LAST_ADDR verifies as erased, a bus write of 00h is issued. After its acknowledge, busy and hvEnable fall and passFlag = 1. passFlag and failFlag are never both 1.
- R10: passFlag and failFlag hold their values while the block is idle. A new start clears both in the next cycle. A start strobe during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a bulk erase |
| hvReady | input | 1 | High-voltage supply has settled |
| busy | output | 1 | A run is in progress |
| passFlag | output | 1 | Last run ended with the whole array erased |
| failFlag | output | 1 | Last run ended in failure |
| hvEnable | output | 1 | Request for the high-voltage supply |
| pgmReq | output | 1 | Request to program one byte, held until pgmDone |
| pgmAddr | output | ADDR_W | Address of the byte to program |
| pgmData | output | 8 | Data to program, always 00h |
| pgmDone | input | 1 | One-cycle completion from the programming engine |
| pgmOk | input | 1 | Programming result, valid with pgmDone |
| busReq | output | 1 | Bus cycle request, held until busAck |
| busWrite | output | 1 | 1 = command write, 0 = read |
| busAddr | output | ADDR_W | Bus cycle address |
| busWdata | output | 8 | Command code for writes |
| busAck | input | 1 | One-cycle bus cycle completion |
| busRdata | input | 8 | Read data, valid with busAck |

## Verification
The assertions check the following on every cycle:
- the pulse counter never goes past its limit;
- the address register stays within range;
- an erase pulse never moves the address;
- request fields stay stable while waiting for an acknowledge;
- the quiet state when idle;
- traffic only under high voltage;
- the two result flags are mutually exclusive.

Other behaviour can only be shown by the bench's scenarios, because it depends on how the external array behaves. These are the pre-program ordering, the settle intervals, resuming at the failing byte, the number of pulses a given array needs, and the early stop at the pulse limit or on a programming failure. The bench gives each byte a random number of pulses it needs before it reads FFh, and it scores the command stream against that model.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HVWAIT,
    ST_PGM,
    ST_ARM,
    ST_FIRE,
    ST_SETTLE,
    ST_VCMD,
    ST_VWAIT,
    ST_VREAD,
    ST_RDCMD
  } seqState_t;

  typedef struct packed {
    logic clrAddr;
    logic incAddr;
    logic clrCnt;
    logic incCnt;
    logic ldErase;
    logic ldVerify;
  } dpCtl_t;

endpackage

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int LAST_ADDR       = 'hFFFF,
  parameter int PULSE_LIMIT     = 1000,
  parameter int ERASE_WAIT_CYC  = 1250000,
  parameter int VERIFY_WAIT_CYC = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              addrLast,
  output logic              cntAtLimit,
  output logic              tmrZero,
  output logic              byteErased
);

  localparam int CNT_W = $clog2(PULSE_LIMIT + 1);
  localparam int WAIT_MAX = (ERASE_WAIT_CYC > VERIFY_WAIT_CYC) ? ERASE_WAIT_CYC : VERIFY_WAIT_CYC;
  localparam int TMR_W = $clog2(WAIT_MAX + 1);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(LAST_ADDR);
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(PULSE_LIMIT);

  logic [CNT_W-1:0] pulseCnt;
  logic [TMR_W-1:0] waitTmr;

  // resume-address register: only moves on explicit clear or step
  always_ff @(posedge clk) begin
    if (!rstN)            curAddr <= '0;
    else if (ctl.clrAddr) curAddr <= '0;
    else if (ctl.incAddr) curAddr <= curAddr + 1'b1;
  end

  // erase pulse counter
  always_ff @(posedge clk) begin
    if (!rstN)           pulseCnt <= '0;
    else if (ctl.clrCnt) pulseCnt <= '0;
    else if (ctl.incCnt) pulseCnt <= pulseCnt + 1'b1;
  end

  // shared settle timer, counts down to zero after a load
  always_ff @(posedge clk) begin
    if (!rstN)               waitTmr <= '0;
    else if (ctl.ldErase)    waitTmr <= TMR_W'(ERASE_WAIT_CYC);
    else if (ctl.ldVerify)   waitTmr <= TMR_W'(VERIFY_WAIT_CYC);
    else if (waitTmr != '0)  waitTmr <= waitTmr - 1'b1;
  end

  assign addrLast   = (curAddr == ADDR_END);
  assign cntAtLimit = (pulseCnt == CNT_END);
  assign tmrZero    = (waitTmr == '0);
  assign byteErased = (rdData == BYTE_ERASED);

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_END); // R8
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    curAddr <= ADDR_END); // R7
  AST_PULSE_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incCnt |=> $stable(curAddr)); // R7

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       hvReady,
  input  logic       busAck,
  input  logic       pgmDone,
  input  logic       pgmOk,
  input  logic       addrLast,
  input  logic       cntAtLimit,
  input  logic       tmrZero,
  input  logic       byteErased,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       passFlag,
  output logic       failFlag,
  output logic       hvEnable,
  output logic       pgmReq,
  output logic       busReq,
  output logic       busWrite,
  output logic [7:0] busWdata
);

  seqState_t st, nxt;
  logic setPass, setFail, clrFlags;

  always_comb begin
    nxt      = st;
    ctl      = '0;
    setPass  = 1'b0;
    setFail  = 1'b0;
    clrFlags = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin
        nxt         = ST_HVWAIT;
        ctl.clrAddr = 1'b1;
        ctl.clrCnt  = 1'b1;
        clrFlags    = 1'b1;
      end
      ST_HVWAIT: if (hvReady) nxt = ST_PGM;
      ST_PGM: if (pgmDone) begin
        if (!pgmOk) begin
          nxt     = ST_IDLE;
          setFail = 1'b1;
        end else if (addrLast) begin
          nxt         = ST_ARM;
          ctl.clrAddr = 1'b1;
        end else begin
          ctl.incAddr = 1'b1;
        end
      end
      ST_ARM: if (busAck) nxt = ST_FIRE;
      ST_FIRE: if (busAck) begin
        nxt         = ST_SETTLE;
        ctl.incCnt  = 1'b1;
        ctl.ldErase = 1'b1;
      end
      ST_SETTLE: if (tmrZero) nxt = ST_VCMD;
      ST_VCMD: if (busAck) begin
        nxt          = ST_VWAIT;
        ctl.ldVerify = 1'b1;
      end
      ST_VWAIT: if (tmrZero) nxt = ST_VREAD;
      ST_VREAD: if (busAck) begin
        if (byteErased) begin
          if (addrLast) nxt = ST_RDCMD;
          else begin
            nxt         = ST_VCMD;
            ctl.incAddr = 1'b1;
          end
        end else if (cntAtLimit) begin
          nxt     = ST_IDLE;
          setFail = 1'b1;
        end else begin
          nxt = ST_ARM;
        end
      end
      ST_RDCMD: if (busAck) begin
        nxt     = ST_IDLE;
        setPass = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passFlag <= 1'b0;
      failFlag <= 1'b0;
    end else if (clrFlags) begin
      passFlag <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      if (setPass) passFlag <= 1'b1;
      if (setFail) failFlag <= 1'b1;
    end
  end

  always_comb begin
    busReq   = 1'b0;
    busWrite = 1'b1;
    busWdata = CMD_READ;
    unique case (st)
      ST_ARM, ST_FIRE: begin busReq = 1'b1; busWdata = CMD_ERASE; end
      ST_VCMD:         begin busReq = 1'b1; busWdata = CMD_VERIFY; end
      ST_VREAD:        begin busReq = 1'b1; busWrite = 1'b0; end
      ST_RDCMD:        begin busReq = 1'b1; busWdata = CMD_READ; end
      default:         ;
    endcase
  end

  assign busy     = (st != ST_IDLE);
  assign hvEnable = busy;
  assign pgmReq   = (st == ST_PGM);

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(passFlag && failFlag)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq && !pgmReq); // R1
  AST_HV_FOR_TRAFFIC: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || pgmReq) |-> hvEnable); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busWrite) && $stable(busWdata)); // R6

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int LAST_ADDR       = 'hFFFF,
  parameter int PULSE_LIMIT     = 1000,
  parameter int ERASE_WAIT_CYC  = 1250000,
  parameter int VERIFY_WAIT_CYC = 750
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              hvReady,
  output logic              busy,
  output logic              passFlag,
  output logic              failFlag,
  output logic              hvEnable,
  output logic              pgmReq,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [7:0]        pgmData,
  input  logic              pgmDone,
  input  logic              pgmOk,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic              busAck,
  input  logic [7:0]        busRdata
);

  dpCtl_t            ctl;
  logic [ADDR_W-1:0] curAddr;
  logic              addrLast, cntAtLimit, tmrZero, byteErased;

  erase_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .hvReady(hvReady),
    .busAck(busAck), .pgmDone(pgmDone), .pgmOk(pgmOk),
    .addrLast(addrLast), .cntAtLimit(cntAtLimit), .tmrZero(tmrZero),
    .byteErased(byteErased), .ctl(ctl), .busy(busy),
    .passFlag(passFlag), .failFlag(failFlag), .hvEnable(hvEnable),
    .pgmReq(pgmReq), .busReq(busReq), .busWrite(busWrite), .busWdata(busWdata)
  );

  erase_seq_dp #(
    .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .PULSE_LIMIT(PULSE_LIMIT),
    .ERASE_WAIT_CYC(ERASE_WAIT_CYC), .VERIFY_WAIT_CYC(VERIFY_WAIT_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdData(busRdata),
    .curAddr(curAddr), .addrLast(addrLast), .cntAtLimit(cntAtLimit),
    .tmrZero(tmrZero), .byteErased(byteErased)
  );

  assign pgmAddr = curAddr;
  assign pgmData = BYTE_ZERO;
  assign busAddr = curAddr;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr)); // R6
  AST_PGM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pgmReq && !pgmDone |=> pgmReq && $stable(pgmAddr)); // R3

endmodule

// File: tb/tb_erase_seq.sv
`timescale 1ns/1ps
module tb_erase_seq;

  localparam int AW = 4;
  localparam int LAST = 11;
  localparam int LIMIT = 3;
  localparam int EW = 20;
  localparam int VW = 5;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, hvReady = 1'b0;
  logic busy, passFlag, failFlag, hvEnable, pgmReq, busReq, busWrite;
  logic [AW-1:0] pgmAddr, busAddr;
  logic [7:0] pgmData, busWdata;
  logic pgmDone = 1'b0, pgmOk = 1'b1, busAck = 1'b0;
  logic [7:0] busRdata = 8'h00;

  erase_seq #(.ADDR_W(AW), .LAST_ADDR(LAST), .PULSE_LIMIT(LIMIT),
              .ERASE_WAIT_CYC(EW), .VERIFY_WAIT_CYC(VW)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int need[0:15];
  bit progd[0:15];
  int pulses, expVer, reads, pgmNext, busTx, gap, waitCnt, busDly, hvDly, hvCnt, pgmFailAt;
  bit armed, afterPulse, verPending, seenRd;
  logic [AW-1:0] verAddr;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expPulses();
    int m = 1;
    for (int a = 0; a <= LAST; a++) if (need[a] > m) m = need[a];
    return m;
  endfunction

  task automatic serveBus();
    busTx++;
    if (busWrite) begin
      if (busWdata == 8'h20) begin
        check(pgmNext == LAST + 1, "R3 preprogram finished before erase", pgmNext, LAST + 1);
        if (armed) begin pulses++; armed = 1'b0; afterPulse = 1'b1; end
        else armed = 1'b1;
      end else if (busWdata == 8'hA0) begin
        check(!armed, "R5 erase writes come in pairs", armed, 0);
        if (afterPulse) check(gap >= EW, "R5 erase settle interval", gap, EW);
        check(int'(busAddr) == expVer, "R7 verify address", busAddr, expVer);
        verAddr = busAddr; verPending = 1'b1; afterPulse = 1'b0;
      end else if (busWdata == 8'h00) begin
        seenRd = 1'b1;
        check(expVer == LAST + 1, "R9 read command after full sweep", expVer, LAST + 1);
      end else begin
        check(1'b0, "R6 unexpected command code", busWdata, 0);
      end
    end else begin
      check(verPending && busAddr == verAddr, "R6 read follows verify command", busAddr, verAddr);
      check(gap >= VW, "R6 verify settle interval", gap, VW);
      reads++;
      if (progd[busAddr] && pulses >= need[busAddr]) begin
        busRdata = 8'hFF; expVer++;
      end else busRdata = 8'h5A;
      verPending = 1'b0;
    end
    gap = 0;
  endtask

  always @(negedge clk) begin
    if (!hvEnable) begin hvReady = 1'b0; hvCnt = 0; end
    else if (hvCnt >= hvDly) hvReady = 1'b1;
    else hvCnt++;
    if (!busReq) gap++;
    if (pgmDone) pgmDone = 1'b0;
    else if (pgmReq) begin
      check(hvReady, "R2 programming only with supply ready", hvReady, 1);
      check(int'(pgmAddr) == pgmNext, "R3 preprogram order", pgmAddr, pgmNext);
      check(pgmData == 8'h00, "R3 preprogram data", pgmData, 0);
      pgmOk = (int'(pgmAddr) != pgmFailAt);
      if (pgmOk) progd[pgmAddr] = 1'b1;
      pgmNext++;
      pgmDone = 1'b1;
    end
    if (busAck) begin busAck = 1'b0; waitCnt = 0; busDly = $urandom_range(0, 2); end
    else if (busReq) begin
      if (waitCnt < busDly) waitCnt++;
      else begin serveBus(); busAck = 1'b1; end
    end
  end

  task automatic resetModel();
    for (int a = 0; a < 16; a++) progd[a] = 1'b0;
    pulses = 0; expVer = 0; reads = 0; pgmNext = 0; busTx = 0; gap = 0;
    armed = 1'b0; afterPulse = 1'b0; verPending = 1'b0; seenRd = 1'b0;
  endtask

  task automatic runOp(input int hvWait, input bit poke);
    int t;
    resetModel();
    hvDly = hvWait;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!passFlag && !failFlag, "R10 start clears result flags", {passFlag, failFlag}, 0);
    check(busy && hvEnable, "R2 busy and supply request after start", {busy, hvEnable}, 3);
    if (hvWait > 4) begin
      repeat (3) @(negedge clk);
      check(!pgmReq && !busReq, "R2 no traffic before supply ready", {pgmReq, busReq}, 0);
    end
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk); t++;
      if (poke && t == 60) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    check(t < 20000, "watchdog run completion", t, 20000);
    check(!hvEnable, "R9 supply request dropped at end", hvEnable, 0);
  endtask

  task automatic expectPass(input string tag);
    int ep = expPulses();
    check(passFlag && !failFlag, {tag, " R9 pass reported"}, {passFlag, failFlag}, 2);
    check(seenRd, {tag, " R9 read command written"}, seenRd, 1);
    check(pulses == ep, {tag, " R7 pulse count"}, pulses, ep);
    check(reads == LAST + ep, {tag, " R7 verify reads resume"}, reads, LAST + ep);
  endtask

  bit wdDone = 1'b0;
  initial begin
    #(8 * 190000);
    if (!wdDone) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    pgmFailAt = -1; hvDly = 0; busDly = 0; waitCnt = 0; hvCnt = 0;
    for (int a = 0; a < 16; a++) need[a] = 1;
    resetModel();
    repeat (4) @(negedge clk);
    check(!busy && !passFlag && !failFlag && !hvEnable && !busReq && !pgmReq,
          "R1 reset state", {busy, passFlag, failFlag, hvEnable, busReq, pgmReq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed: all bytes erase on first pulse, slow supply, stray start mid-run
    runOp(10, 1'b1);
    expectPass("single pulse");
    repeat (5) @(negedge clk);
    check(passFlag && !busy, "R10 pass held while idle", passFlag, 1);

    // random pulse needs per byte
    for (int it = 0; it < 4; it++) begin
      for (int a = 0; a <= LAST; a++) need[a] = $urandom_range(0, LIMIT);
      runOp($urandom_range(0, 3), 1'b0);
      expectPass("random");
    end

    // directed: last address needs the most pulses
    for (int a = 0; a <= LAST; a++) need[a] = 1;
    need[LAST] = LIMIT;
    runOp(0, 1'b0);
    expectPass("last address");

    // directed: one byte never erases within the limit
    need[7] = LIMIT + 1;
    runOp(0, 1'b0);
    check(failFlag && !passFlag, "R8 fail at pulse limit", {passFlag, failFlag}, 1);
    check(pulses == LIMIT, "R8 pulses capped", pulses, LIMIT);
    check(!seenRd, "R8 no read command on fail", seenRd, 0);
    repeat (5) @(negedge clk);
    check(failFlag, "R10 fail held while idle", failFlag, 1);

    // directed: programming engine reports failure
    for (int a = 0; a <= LAST; a++) need[a] = 1;
    pgmFailAt = 5;
    runOp(0, 1'b0);
    check(failFlag && !passFlag, "R4 fail on program error", {passFlag, failFlag}, 1);
    check(pgmNext == 6, "R4 programming stopped", pgmNext, 6);
    check(busTx == 0, "R4 no bus cycle after program error", busTx, 0);
    pgmFailAt = -1;

    // recovery after a failure
    runOp(2, 1'b0);
    expectPass("recovery");

    wdDone = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule